// File: doc/BRIEF.md
# Execution Mask Unit

This block keeps the per-lane enable mask of a wide vector engine and performs the scalar mask operations that turn structured control flow into predication. When a branch diverges, a fused save-and-modify operation hands the old mask to the scalar register file and narrows the live mask in the same cycle. No hardware predicate stack is needed, because the saved masks live in ordinary scalar registers. Loops, breaks and lane kills are built from plain logical updates of the mask.

Each cycle the unit takes one opcode, a condition mask written by the lanes, a scalar source operand and a per-lane sign vector that kills use. The live mask is a register. A result for the scalar register file comes out with a write strobe. Two flags, mask-is-zero and mask-is-non-zero, let the sequencer skip blocks that have no active lanes and close loops.

Top module: `exec_mask_unit`

## Requirements
- R1: A synchronous active-low reset sets the mask to all ones, the result to zero and the write strobe low. Reset takes priority over any opcode presented in the same cycle.
- R2: Opcode 1 (and-save) returns the old mask as the result with the strobe high. The new mask is the old mask AND the condition input.
- R3: Opcode 9 (park) returns the source XOR the current mask with the strobe high, and leaves the mask unchanged. This yields the lanes that failed an if-condition.
- R4: Opcode 2 (or-save) returns the old mask as the result with the strobe high. The new mask is the old mask OR the source.
- R5: Opcode 3 (flip) sets the mask to the mask XOR the source, keeping only previously parked lanes. The strobe is low.
- R6: Opcode 4 (rejoin) sets the mask to the mask OR the source, re-enabling saved lanes at the end of a construct. The strobe is low.
- R7: Opcode 5 (loop-exit) clears the source's bits from the mask (mask AND NOT source). The strobe is low.
- R8: Opcode 6 (break-live) returns mask OR source. Opcode 7 (break-cond) returns condition OR source. Both raise the strobe and leave the mask unchanged.
- R9: Opcode 8 (kill) clears each mask bit whose sign input bit is 1. It never sets a bit. The strobe is low.
- R10: The zero flag is high exactly when the registered mask is all zero, and the non-zero flag is its complement. Both follow the mask in the cycle after the updating edge.
- R11: Opcode 0 and the unused codes 10 to 15 leave the mask and the result unchanged with the strobe low. Every mask-only opcode also holds the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| cond_i | input | 64 | Per-lane condition mask |
| src_i | input | 64 | Scalar source operand |
| neg_i | input | 64 | Per-lane sign bits for kill (1 = negative) |
| exec_o | output | 64 | Registered execution mask |
| result_o | output | 64 | Scalar result for the register file |
| result_we_o | output | 1 | Result write strobe, registered with the result |
| mask_zero_o | output | 1 | High when no lane is active |
| mask_nonzero_o | output | 1 | High when at least one lane is active |

## Verification
The bench builds the unit with its defaults: 64 lanes and an 8-lane flag group, which gives eight equal groups in the flag reduction. At that width the stimulus runs a full if/else/end sequence across the upper and lower halves. It then runs a kill, breaks and two loop exits that drive the mask from a single group down to zero, so both flags are exercised. Saving a mask that is already empty, an unused opcode, and a reset that collides with an update are also driven at full width.

// File: rtl/exmask_pkg.sv
// Package: shared opcode encoding of the execution mask unit.
// Assumes a 4-bit opcode field; codes not listed act as no-ops.
package exmask_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_AND_SAVE  = 4'd1,
        OP_OR_SAVE   = 4'd2,
        OP_FLIP      = 4'd3,
        OP_REJOIN    = 4'd4,
        OP_LOOP_EXIT = 4'd5,
        OP_BRK_LIVE  = 4'd6,
        OP_BRK_COND  = 4'd7,
        OP_KILL      = 4'd8,
        OP_PARK      = 4'd9
    } mask_op_e;
endpackage

// File: rtl/exmask_alu.sv
// Module: combinational next-state logic of the mask unit.
// Computes the next mask, the next scalar result and which of the two are
// written. Assumes the opcode is valid every cycle; unknown codes do nothing.
module exmask_alu
    import exmask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic [OP_W-1:0]  op,
    input  logic [LANES-1:0] exec_cur,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] src,
    input  logic [LANES-1:0] neg,
    output logic [LANES-1:0] exec_nxt,
    output logic             exec_upd,
    output logic [LANES-1:0] res_nxt,
    output logic             res_upd
);
    logic [LANES-1:0] survive;

    // Per-lane kill compare: a lane survives only if enabled and not negative.
    for (genvar l = 0; l < LANES; l++) begin : g_kill
        assign survive[l] = exec_cur[l] & ~neg[l];
    end

    // Opcode decode: select the mask and result updates.
    always_comb begin
        exec_nxt = exec_cur;
        exec_upd = 1'b0;
        res_nxt  = '0;
        res_upd  = 1'b0;
        case (mask_op_e'(op))
            OP_AND_SAVE: begin
                res_nxt  = exec_cur;
                res_upd  = 1'b1;
                exec_nxt = exec_cur & cond;
                exec_upd = 1'b1;
            end
            OP_OR_SAVE: begin
                res_nxt  = exec_cur;
                res_upd  = 1'b1;
                exec_nxt = exec_cur | src;
                exec_upd = 1'b1;
            end
            OP_FLIP: begin
                exec_nxt = exec_cur ^ src;
                exec_upd = 1'b1;
            end
            OP_REJOIN: begin
                exec_nxt = exec_cur | src;
                exec_upd = 1'b1;
            end
            OP_LOOP_EXIT: begin
                exec_nxt = exec_cur & ~src;
                exec_upd = 1'b1;
            end
            OP_BRK_LIVE: begin
                res_nxt = exec_cur | src;
                res_upd = 1'b1;
            end
            OP_BRK_COND: begin
                res_nxt = cond | src;
                res_upd = 1'b1;
            end
            OP_KILL: begin
                exec_nxt = survive;
                exec_upd = 1'b1;
            end
            OP_PARK: begin
                res_nxt = src ^ exec_cur;
                res_upd = 1'b1;
            end
            default: begin
                exec_upd = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exmask_regs.sv
// Module: state registers of the mask unit.
// Holds the live mask, the last scalar result and its write strobe.
// Synchronous active-low reset; the mask resets to all lanes enabled.
module exmask_regs #(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] exec_nxt,
    input  logic             exec_upd,
    input  logic [LANES-1:0] res_nxt,
    input  logic             res_upd,
    output logic [LANES-1:0] exec_q,
    output logic [LANES-1:0] res_q,
    output logic             we_q
);
    // Mask register: loads on a mask-writing opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)        exec_q <= '1;
        else if (exec_upd) exec_q <= exec_nxt;
    end

    // Result register: loads on a result-writing opcode, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (res_upd) res_q <= res_nxt;
    end

    // Write strobe: one cycle high with each new result.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b0;
        else        we_q <= res_upd;
    end
endmodule

// File: rtl/exmask_flags.sv
// Module: zero / non-zero detection on the registered mask.
// Reduces the mask in groups of GROUP_W lanes, then across groups.
// Assumes GROUP_W >= 1; a short last group is padded with zeros.
module exmask_flags #(
    parameter int LANES   = 64,
    parameter int GROUP_W = 8
) (
    input  logic [LANES-1:0] mask,
    output logic             is_zero,
    output logic             is_nonzero
);
    localparam int NGROUP = (LANES + GROUP_W - 1) / GROUP_W;
    localparam int PAD_W  = NGROUP * GROUP_W;

    logic [PAD_W-1:0]  padded;
    logic [NGROUP-1:0] grp_any;

    // Pad the mask to a whole number of groups.
    always_comb begin
        padded            = '0;
        padded[LANES-1:0] = mask;
    end

    // First level: one OR per lane group.
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        assign grp_any[g] = |padded[g*GROUP_W +: GROUP_W];
    end

    // Second level: combine the groups into the two flags.
    assign is_nonzero = |grp_any;
    assign is_zero    = ~is_nonzero;
endmodule

// File: rtl/exec_mask_unit.sv
// Module: execution mask unit top.
// Wires the decode, state and flag stages. All updates land on the next
// rising edge; the flags follow the registered mask combinationally.
module exec_mask_unit
    import exmask_pkg::*;
#(
    parameter int LANES   = 64,
    parameter int GROUP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [LANES-1:0] cond_i,
    input  logic [LANES-1:0] src_i,
    input  logic [LANES-1:0] neg_i,
    output logic [LANES-1:0] exec_o,
    output logic [LANES-1:0] result_o,
    output logic             result_we_o,
    output logic             mask_zero_o,
    output logic             mask_nonzero_o
);
    logic [LANES-1:0] exec_nxt, res_nxt;
    logic             exec_upd, res_upd;

    exmask_alu #(.LANES(LANES)) alu_i (
        .op(op_i), .exec_cur(exec_o), .cond(cond_i), .src(src_i), .neg(neg_i),
        .exec_nxt(exec_nxt), .exec_upd(exec_upd),
        .res_nxt(res_nxt), .res_upd(res_upd)
    );

    exmask_regs #(.LANES(LANES)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .exec_nxt(exec_nxt), .exec_upd(exec_upd),
        .res_nxt(res_nxt), .res_upd(res_upd),
        .exec_q(exec_o), .res_q(result_o), .we_q(result_we_o)
    );

    exmask_flags #(.LANES(LANES), .GROUP_W(GROUP_W)) flags_i (
        .mask(exec_o), .is_zero(mask_zero_o), .is_nonzero(mask_nonzero_o)
    );

    // Reset leaves every lane enabled and no pending write.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (exec_o == '1 && result_o == '0 && !result_we_o));

    // And-save: old mask out, narrowed mask in.
    assert_and_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_AND_SAVE)) |=>
        (exec_o == $past(exec_o & cond_i) && result_o == $past(exec_o) && result_we_o));

    // Or-save: old mask out, widened mask in.
    assert_or_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_OR_SAVE)) |=>
        (exec_o == $past(exec_o | src_i) && result_o == $past(exec_o)));

    // Loop exit leaves none of the source lanes active.
    assert_loop_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_LOOP_EXIT)) |=> ((exec_o & $past(src_i)) == '0));

    // Kill only removes lanes, and removes every negative one.
    assert_kill_only_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_KILL)) |=>
        ((exec_o & ~$past(exec_o)) == '0 && (exec_o & $past(neg_i)) == '0));

    // Flags are complementary and track an empty mask.
    assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_zero_o != mask_nonzero_o) && (mask_zero_o == ($countones(exec_o) == 0)));

    // No-op holds all state and writes nothing.
    assert_nop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'(OP_NOP)) |=> ($stable(exec_o) && $stable(result_o) && !result_we_o));
endmodule

// File: tb/exec_mask_unit_tb_top.sv
`timescale 1ns/1ps
module exec_mask_unit_tb_top;
    localparam int L = 64;
    localparam logic [L-1:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [L-1:0] LO  = 64'h0000_0000_FFFF_FFFF;
    localparam logic [L-1:0] HI  = 64'hFFFF_FFFF_0000_0000;
    localparam logic [L-1:0] K1  = 64'hFFFF_FFFF_FFFF_FF00;
    localparam logic [L-1:0] BR  = 64'h0000_0001_0000_0003;

    typedef struct packed {
        logic [3:0]   op;
        logic [L-1:0] cond;
        logic [L-1:0] src;
        logic [L-1:0] neg;
        logic [L-1:0] exp_exec;
        logic [L-1:0] exp_res;
        logic         exp_we;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd1, LO,   '0,   '0,   LO,   ALL,  1'b1},   // and-save
        '{4'd9, '0,   ALL,  '0,   LO,   HI,   1'b1},   // park
        '{4'd2, '0,   HI,   '0,   ALL,  LO,   1'b1},   // or-save
        '{4'd3, '0,   LO,   '0,   HI,   LO,   1'b0},   // flip
        '{4'd4, '0,   LO,   '0,   ALL,  LO,   1'b0},   // rejoin
        '{4'd8, '0,   '0,   64'hFF, K1, LO,   1'b0},   // kill
        '{4'd6, '0,   64'h0F, '0, K1, 64'hFFFF_FFFF_FFFF_FF0F, 1'b1},
        '{4'd7, 64'h1_0000_0000, 64'h3, '0, K1, BR, 1'b1},
        '{4'd5, '0,   64'hFFFF_FFFF_FFFF_0000, '0, 64'hFF00, BR, 1'b0},
        '{4'd5, '0,   64'hFF00, '0, '0,  BR,   1'b0},  // loop exit to empty
        '{4'd0, ALL,  ALL,  ALL,  '0,   BR,   1'b0},   // nop
        '{4'd15, ALL, ALL,  ALL,  '0,   BR,   1'b0},   // unused code
        '{4'd1, ALL,  '0,   '0,   '0,   '0,   1'b1},   // save of empty mask
        '{4'd4, '0,   ALL,  '0,   ALL,  '0,   1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [L-1:0] cond_i = '0, src_i = '0, neg_i = '0;
    logic [L-1:0] exec_o, result_o;
    logic result_we_o, mask_zero_o, mask_nonzero_o;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exec_mask_unit #(.LANES(L), .GROUP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i), .src_i(src_i),
        .neg_i(neg_i), .exec_o(exec_o), .result_o(result_o),
        .result_we_o(result_we_o), .mask_zero_o(mask_zero_o),
        .mask_nonzero_o(mask_nonzero_o)
    );

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd1: return "R2";
            4'd9: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, string what, logic [L-1:0] act, logic [L-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Flag check for R10 against the bench's own view of the mask.
    task automatic check_flags(logic [L-1:0] exp_mask);
        check("R10", "zero flag", {63'd0, mask_zero_o}, {63'd0, exp_mask == '0});
        check("R10", "nonzero flag", {63'd0, mask_nonzero_o}, {63'd0, exp_mask != '0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state after reset
        rst_n = 1'b1;
        check("R1", "mask", exec_o, ALL);
        check("R1", "result", result_o, '0);
        check("R1", "strobe", {63'd0, result_we_o}, '0);
        check_flags(ALL);

        for (int i = 0; i < NV; i++) begin
            op_i = VEC[i].op; cond_i = VEC[i].cond;
            src_i = VEC[i].src; neg_i = VEC[i].neg;
            @(negedge clk);
            check(req_of(VEC[i].op), "mask", exec_o, VEC[i].exp_exec);
            check(req_of(VEC[i].op), "result", result_o, VEC[i].exp_res);
            check(req_of(VEC[i].op), "strobe", {63'd0, result_we_o}, {63'd0, VEC[i].exp_we});
            check_flags(VEC[i].exp_exec);
        end

        // R9: kill of every lane empties the mask
        op_i = 4'd8; neg_i = ALL;
        @(negedge clk);
        check("R9", "full kill", exec_o, '0);
        check_flags('0);

        // R9: kill cannot revive lanes; rejoin one lane, kill with none negative
        op_i = 4'd4; src_i = 64'h8000_0000_0000_0000;
        @(negedge clk);
        op_i = 4'd8; neg_i = '0;
        @(negedge clk);
        check("R9", "kill keeps", exec_o, 64'h8000_0000_0000_0000);

        // R1: reset wins over an and-save in the same cycle
        rst_n = 1'b0; op_i = 4'd1; cond_i = '0;
        @(negedge clk);
        check("R1", "reset vs op mask", exec_o, ALL);
        check("R1", "reset vs op strobe", {63'd0, result_we_o}, '0);
        check("R1", "reset vs op result", result_o, '0);
        rst_n = 1'b1; op_i = 4'd0;
        @(negedge clk);
        check("R11", "idle after reset", exec_o, ALL);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule